// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a small group of already-synchronized input pins and raises an interrupt flag when any pin that software has armed no longer matches the value recorded at the last port access. Every read or write of the port reloads that recorded snapshot from the live pins, which ends the mismatch. Software handles the interrupt in two steps. It first accesses the port and then pulses the flag-clear strobe. The flag refuses to clear while a mismatch is still present.

Two resets drive the block. Power-on reset clears the flag and the arm bits, and it loads the snapshot from the pins. Warm reset clears only the flag. The snapshot and arm bits survive it, so a mismatch that was pending before the warm reset raises the flag again right after it. A wake output is high while the flag is set or any armed mismatch exists. The mismatch part of that output is combinational, so it can wake a sleeping system without any strobe from a processor.

Top module: `pin_change_irq`

## Requirements
- R1: While por_n is low at a clock edge, the flag clears, all arm bits clear, and the snapshot loads from pins_i. Pin activity after power-on reset therefore raises neither flag_o nor wake_o until arm bits are written.
- R2: When en_wr_i is high at an edge, the arm register loads en_wdata_i. Bit k arms pin k. The new arm value governs comparison from the following cycle.
- R3: When warm_rst_n and por_n are high, port_acc_i is low, and an armed pin differs from its snapshot bit, flag_o is 1 after the next edge.
- R4: A difference on a pin whose arm bit is 0 has no effect on flag_o or wake_o.
- R5: When port_acc_i is high at an edge, the snapshot loads from pins_i. From the next cycle the comparison uses the new snapshot, and warm reset does not alter the snapshot.
- R6: A clear strobe in a cycle where an armed mismatch exists and no port access occurs leaves flag_o at 1. Set wins over clear.
- R7: A clear strobe with no armed mismatch, or one that coincides with a port access, makes flag_o 0 after the edge.
- R8: When warm_rst_n is low at an edge, flag_o becomes 0, and the arm bits and snapshot are kept. A mismatch still present afterwards sets the flag again on the next edge.
- R9: wake_o equals flag_o OR the presence of any armed mismatch. The mismatch term is combinational on pins_i.
- R10: A port access masks flag setting in its own cycle. A pin change that lands in the access cycle is absorbed into the snapshot and raises no flag. Without a clear, flag_o holds its value across an access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset (flag only) |
| pins_i | input | PIN_W (6) | Synchronized pin values |
| port_acc_i | input | 1 | Port read or write strobe; reloads snapshot |
| flag_clr_i | input | 1 | Flag clear strobe |
| en_wr_i | input | 1 | Arm register write strobe |
| en_wdata_i | input | PIN_W (6) | Arm register write data |
| flag_o | output | 1 | Sticky change flag |
| wake_o | output | 1 | Wake request |

## Verification
Two functions can collide in one cycle. A port access reloads the snapshot, and a pin transition or clear strobe can arrive in that same cycle. A separate collision occurs when a clear strobe meets a mismatch that still persists. The bench provokes both. It changes an armed pin in the same cycle as an access strobe and expects no flag with a silent wake afterwards. It pulses clear together with an access, and it pulses clear alone while a mismatch stands. It judges the results from flag_o and wake_o sampled one cycle later, which also exposes whether the snapshot absorbed the late change.

// File: rtl/pcd_pkg.sv
// Package: shared types for the port change interrupt detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pcd_pkg;
    // Next action taken by the flag register, listed from highest priority.
    typedef enum logic [1:0] {
        FL_RST  = 2'd0,
        FL_SET  = 2'd1,
        FL_CLR  = 2'd2,
        FL_HOLD = 2'd3
    } flag_act_e;
endpackage

// File: rtl/pcd_arm_reg.sv
// Module: pcd_arm_reg
// Holds the per-pin arm bits. Only power-on reset clears them; warm reset
// leaves them alone so a pending change can re-raise the flag.
// Assumes: the write strobe is synchronous to clk.
module pcd_arm_reg #(
    parameter int PIN_W = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_i,
    input  logic [PIN_W-1:0] wdata_i,
    output logic [PIN_W-1:0] arm_q
);
    // Arm register: cleared at power-on, loaded on write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            arm_q <= '0;
        end else if (wr_i) begin
            arm_q <= wdata_i;
        end
    end
endmodule

// File: rtl/pcd_snapshot.sv
// Module: pcd_snapshot
// Latches the pin values at each port access and at power-on reset.
// Warm reset is deliberately not an input: the snapshot survives it.
// Assumes: pins_i is already synchronized to clk.
module pcd_snapshot #(
    parameter int PIN_W = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [PIN_W-1:0] pins_i,
    output logic [PIN_W-1:0] snap_q
);
    // Snapshot latch: reload from the pins on power-on or port access.
    always_ff @(posedge clk) begin
        if (!por_n || load_i) begin
            snap_q <= pins_i;
        end
    end
endmodule

// File: rtl/pcd_compare.sv
// Module: pcd_compare
// Per-pin mismatch detection against the snapshot, gated by the arm bits,
// reduced to a single any-mismatch signal. Purely combinational.
// Assumes: all inputs are in the clk domain.
module pcd_compare #(
    parameter int PIN_W = 6
) (
    input  logic [PIN_W-1:0] pins_i,
    input  logic [PIN_W-1:0] snap_i,
    input  logic [PIN_W-1:0] arm_i,
    output logic             any_o
);
    logic [PIN_W-1:0] pin_mis;

    // One armed XOR comparator per pin.
    for (genvar k = 0; k < PIN_W; k++) begin : g_pin
        assign pin_mis[k] = arm_i[k] & (pins_i[k] ^ snap_i[k]);
    end

    // OR-reduce the per-pin results.
    assign any_o = |pin_mis;
endmodule

// File: rtl/pcd_flag.sv
// Module: pcd_flag
// Sticky change flag. Priority: any reset, then set, then clear, then hold.
// Assumes: set_i is already masked during port-access cycles by the parent.
module pcd_flag (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    import pcd_pkg::*;

    flag_act_e act;

    // Choose the flag action for this cycle.
    always_comb begin
        if (!por_n || !warm_rst_n) begin
            act = FL_RST;
        end else if (set_i) begin
            act = FL_SET;
        end else if (clr_i) begin
            act = FL_CLR;
        end else begin
            act = FL_HOLD;
        end
    end

    // Flag register update.
    always_ff @(posedge clk) begin
        case (act)
            FL_RST:  flag_q <= 1'b0;
            FL_SET:  flag_q <= 1'b1;
            FL_CLR:  flag_q <= 1'b0;
            default: flag_q <= flag_q;
        endcase
    end
endmodule

// File: rtl/pin_change_irq.sv
// Module: pin_change_irq (top)
// Port change interrupt detector: arm bits, an access-loaded snapshot,
// a masked comparator, and a sticky flag that cannot clear while a
// mismatch persists. Also drives a wake request.
// Assumes: pins_i is synchronized; strobes are single-cycle in clk.
module pin_change_irq #(
    parameter int PIN_W = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             port_acc_i,
    input  logic             flag_clr_i,
    input  logic             en_wr_i,
    input  logic [PIN_W-1:0] en_wdata_i,
    output logic             flag_o,
    output logic             wake_o
);
    logic [PIN_W-1:0] arm_q;
    logic [PIN_W-1:0] snap_q;
    logic             mis_any;
    logic             set_req;

    pcd_arm_reg #(.PIN_W(PIN_W)) u_arm (
        .clk     (clk),
        .por_n   (por_n),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .arm_q   (arm_q)
    );

    pcd_snapshot #(.PIN_W(PIN_W)) u_snap (
        .clk    (clk),
        .por_n  (por_n),
        .load_i (port_acc_i),
        .pins_i (pins_i),
        .snap_q (snap_q)
    );

    pcd_compare #(.PIN_W(PIN_W)) u_cmp (
        .pins_i (pins_i),
        .snap_i (snap_q),
        .arm_i  (arm_q),
        .any_o  (mis_any)
    );

    // An access reloads the snapshot, so it masks setting in its own cycle.
    assign set_req = mis_any & ~port_acc_i;

    pcd_flag u_flag (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .set_i      (set_req),
        .clr_i      (flag_clr_i),
        .flag_q     (flag_o)
    );

    // Wake needs no clock edge for the mismatch term.
    assign wake_o = flag_o | mis_any;
endmodule

// File: rtl/pin_change_irq_chk.sv
// Module: pin_change_irq_chk
// Assertion checker bound into pin_change_irq. Observes ports plus the
// snapshot, arm register and comparator output.
// Assumes: bound with the same PIN_W as the host.
module pin_change_irq_chk #(
    parameter int PIN_W = 6
) (
    input logic             clk,
    input logic             por_n,
    input logic             warm_rst_n,
    input logic [PIN_W-1:0] pins_i,
    input logic             port_acc_i,
    input logic             flag_clr_i,
    input logic             en_wr_i,
    input logic [PIN_W-1:0] en_wdata_i,
    input logic             flag_o,
    input logic             wake_o,
    input logic [PIN_W-1:0] snap_q,
    input logic [PIN_W-1:0] arm_q,
    input logic             mis_any
);
    // R2: arm register takes written data.
    p_arm_write_r2: assert property (@(posedge clk) disable iff (!por_n)
        en_wr_i |=> arm_q == $past(en_wdata_i));

    // R3: armed mismatch without access sets the flag.
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && !port_acc_i && mis_any) |=> flag_o);

    // R5: access loads the snapshot from the pins.
    p_snap_load_r5: assert property (@(posedge clk) disable iff (!por_n)
        port_acc_i |=> snap_q == $past(pins_i));

    // R5: without access the snapshot is steady, warm reset included.
    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        !port_acc_i |=> $stable(snap_q));

    // R6: clear is refused while a mismatch persists.
    p_clr_blocked_r6: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && flag_clr_i && mis_any && !port_acc_i) |=> flag_o);

    // R7: clear with no mismatch takes effect.
    p_clr_done_r7: assert property (@(posedge clk) disable iff (!por_n)
        (flag_clr_i && !mis_any) |=> !flag_o);

    // R8: warm reset clears the flag.
    p_warm_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> !flag_o);

    // R8: warm reset keeps the arm bits.
    p_warm_arm_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!warm_rst_n && !en_wr_i) |=> $stable(arm_q));

    // R9: a set flag always drives wake.
    p_wake_flag_r9: assert property (@(posedge clk) disable iff (!por_n)
        flag_o |-> wake_o);

    // R10: access without clear holds the flag.
    p_acc_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (port_acc_i && !flag_clr_i && warm_rst_n) |=> flag_o == $past(flag_o));
endmodule

bind pin_change_irq pin_change_irq_chk #(.PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .pins_i     (pins_i),
    .port_acc_i (port_acc_i),
    .flag_clr_i (flag_clr_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .flag_o     (flag_o),
    .wake_o     (wake_o),
    .snap_q     (snap_q),
    .arm_q      (arm_q),
    .mis_any    (mis_any)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
    localparam int PIN_W = 6;
    localparam int NVEC  = 16;

    // Vector: pins, en_wr, en_data, acc, clr, warm_n, exp_flag, exp_wake
    typedef struct packed {
        logic [5:0] pins;
        logic       en_wr;
        logic [5:0] en_d;
        logic       acc;
        logic       clr;
        logic       warm_n;
        logic       exp_flag;
        logic       exp_wake;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{6'h01, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 unarmed
        '{6'h01, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 R9
        '{6'h01, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        '{6'h01, 1'b0, 6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6
        '{6'h01, 1'b0, 6'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 R10
        '{6'h01, 1'b0, 6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
        '{6'h01, 1'b1, 6'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
        '{6'h21, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
        '{6'h23, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        '{6'h23, 1'b0, 6'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 R5
        '{6'h21, 1'b0, 6'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
        '{6'h23, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3
        '{6'h23, 1'b0, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 R9
        '{6'h23, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R8
        '{6'h23, 1'b0, 6'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R10
        '{6'h23, 1'b0, 6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R7
    };

    logic             clk = 1'b0;
    logic             por_n;
    logic             warm_rst_n;
    logic [PIN_W-1:0] pins_i;
    logic             port_acc_i;
    logic             flag_clr_i;
    logic             en_wr_i;
    logic [PIN_W-1:0] en_wdata_i;
    logic             flag_o;
    logic             wake_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pin_change_irq #(.PIN_W(PIN_W)) u_pin_change_irq (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .pins_i     (pins_i),
        .port_acc_i (port_acc_i),
        .flag_clr_i (flag_clr_i),
        .en_wr_i    (en_wr_i),
        .en_wdata_i (en_wdata_i),
        .flag_o     (flag_o),
        .wake_o     (wake_o)
    );

    task automatic check(input string req, input logic exp_f, input logic exp_w);
        checks++;
        if (flag_o !== exp_f || wake_o !== exp_w) begin
            failures++;
            $display("FAIL %s flag=%b wake=%b expected flag=%b wake=%b",
                     req, flag_o, wake_o, exp_f, exp_w);
        end
    endtask

    task automatic idle_inputs();
        port_acc_i = 1'b0;
        flag_clr_i = 1'b0;
        en_wr_i    = 1'b0;
        en_wdata_i = '0;
        warm_rst_n = 1'b1;
    endtask

    // One cycle: drive after a falling edge, check at the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        por_n  = 1'b0;
        pins_i = 6'h00;
        idle_inputs();
        @(negedge clk);
        step();
        por_n = 1'b1;
        check("R1 reset state", 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            pins_i     = VECS[i].pins;
            en_wr_i    = VECS[i].en_wr;
            en_wdata_i = VECS[i].en_d;
            port_acc_i = VECS[i].acc;
            flag_clr_i = VECS[i].clr;
            warm_rst_n = VECS[i].warm_n;
            step();
            check($sformatf("vector %0d", i), VECS[i].exp_flag, VECS[i].exp_wake);
        end
        idle_inputs();

        // R1: power-on reset with flag clear pending, new pins captured.
        pins_i = 6'h15;
        por_n  = 1'b0;
        step();
        por_n = 1'b1;
        check("R1 por clears flag", 1'b0, 1'b0);
        pins_i = 6'h2A;
        step();
        check("R1 arm bits cleared", 1'b0, 1'b0);
        pins_i     = 6'h15;
        en_wr_i    = 1'b1;
        en_wdata_i = 6'h3F;
        step();
        idle_inputs();
        check("R1 snapshot loaded at por", 1'b0, 1'b0);
        pins_i = 6'h14;
        step();
        check("R3 after por", 1'b1, 1'b1);
        pins_i = 6'h15;
        step();
        check("R9 flag keeps wake", 1'b1, 1'b1);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule